// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Controller

This block sits between an interrupt routing unit and one processor. The routing unit offers source indices to it. The block filters each offer against the processor's current task priority and keeps two bitmaps of source indices. The pending bitmap holds interrupts that are waiting to be taken. The in-service bitmap holds interrupts the processor has taken but not yet retired. Because the two bitmaps are separate, an interrupt of higher priority can nest over one that is already being serviced.

The block does not store source attributes. The per-source priority, vector, sense, activity flag and destination word reach it on flat table buses from the source unit. The block answers with one-hot pulses that set or clear a source's activity flag. An acknowledge read returns the vector of the highest pending source, or the spurious vector when no valid candidate exists. An end-of-interrupt write retires the highest in-service source. When the destination word marks a source as critical for this processor, the block raises a separate critical output line instead of the normal one.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, `irq_out` and `crit_out` are low and `task_prio` is 15. Both bitmaps are empty, and the spurious vector register holds all ones in its SPUR_W bits, so an acknowledge on an empty block returns 0x00FF when SPUR_W is 8.
- R2: An offer whose source priority is less than or equal to `task_prio` is dropped. It produces no activity pulse, no missed pulse and no change of state.
- R3: An offer above the task priority for a source that is already pending pulses `offer_missed` in that cycle, with no activity pulse and no change of state.
- R4: An accepted offer pulses `act_set` for that source and adds the source to the pending bitmap. From the next cycle an output line is high if two conditions hold: the source's priority is not below any priority already pending, and it is strictly above the highest in-service priority. An empty bitmap counts as priority 0.
- R5: The highest member of a bitmap is the one with the strictly greatest priority. On a tie, the lowest index wins.
- R6: An acknowledge drives both output lines low from the next cycle. On an empty pending bitmap, it returns the spurious vector, zero-extended to VEC_W.
- R7: If the highest pending source is inactive, or its priority is not above `task_prio`, an acknowledge returns the spurious vector, pulses `act_clr` for that source and removes it from the pending bitmap.
- R8: Otherwise an acknowledge returns the source's vector and moves the source from pending to in-service. `act_clr` pulses only when the source is edge-sensitive (`src_level` bit 0).
- R9: An end-of-interrupt removes the highest in-service source. If the highest pending priority is then above the new highest in-service priority, an output line is high from the next cycle.
- R10: When CRIT_EN is 1 and bit 30−CPU_IDX of the source's 32-bit destination word is 1, the block raises `crit_out` instead of `irq_out`.
- R11: A spurious-vector write keeps only the low SPUR_W bits of the written value.
- R12: Only one command acts per cycle: acknowledge first, then end-of-interrupt, then offer. A command that loses is ignored.
- R13: A task-priority write stores the 4-bit value at the next edge. Without a write, `task_prio` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | The routing unit offers a source this cycle |
| offer_idx | input | IW | Index of the offered source |
| offer_missed | output | 1 | The offered source was already pending |
| src_prio | input | N*PW | Priority of every source, packed by index |
| src_vec | input | N*VEC_W | Vector of every source |
| src_level | input | N | 1 = level-sensitive, 0 = edge-sensitive |
| src_active | input | N | Activity flag of every source |
| src_dest | input | N*32 | Destination word of every source |
| act_set | output | N | One-hot pulse that sets a source's activity flag |
| act_clr | output | N | One-hot pulse that clears a source's activity flag |
| tp_we | input | 1 | Task priority write strobe |
| tp_wdata | input | 4 | Task priority write data |
| task_prio | output | 4 | Current task priority |
| spur_we | input | 1 | Spurious vector write strobe |
| spur_wdata | input | VEC_W | Spurious vector write data |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_vec | output | VEC_W | Vector returned during an acknowledge |
| eoi_we | input | 1 | End-of-interrupt write strobe |
| irq_out | output | 1 | Normal interrupt line |
| crit_out | output | 1 | Critical interrupt line |

## Verification
The bench builds the block with four sources, 4-bit priorities, 16-bit vectors and an 8-bit spurious register, as CPU 1 with critical support on, so the critical bit sits at position 29. With four sources, every tie-break and nesting order can be written out directly. The bench sweeps all 256 pairs of task priority and source priority, checking both drop and acceptance. It also exercises the spurious-vector truncation and the critical-bit position that belongs to a nonzero CPU index.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int TP_W = 4;
  localparam int DEST_W = 32;

  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_OFFER,
    CMD_ACK,
    CMD_EOI
  } ack_cmd_e;
endpackage

// File: rtl/prio_pick.sv
// Picks the member with the strictly greatest priority; the lowest index wins a tie.
module prio_pick #(
  parameter int N  = 8,
  parameter int PW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    member,
  input  logic [N*PW-1:0] prio_flat,
  output logic            any,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   top
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    top = '0;
    for (int i = 0; i < N; i++) begin
      if (member[i] && (!any || prio_flat[i*PW +: PW] > top)) begin
        any = 1'b1;
        idx = IW'(i);
        top = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/src_bitmap.sv
// One flop per source index with per-bit set and clear enables; a set wins.
module src_bitmap #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_oh,
  input  logic [N-1:0] clr_oh,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic en;
    logic d;
    always_comb begin
      en = set_oh[g] | clr_oh[g];
      d  = set_oh[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[g] <= 1'b0;
      else if (en) q[g] <= d;
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int N       = 8,
  parameter int PW      = 4,
  parameter int VEC_W   = 16,
  parameter int SPUR_W  = 8,
  parameter int CPU_IDX = 0,
  parameter bit CRIT_EN = 1'b1,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_valid,
  input  logic [IW-1:0]     offer_idx,
  output logic              offer_missed,
  input  logic [N*PW-1:0]   src_prio,
  input  logic [N*VEC_W-1:0] src_vec,
  input  logic [N-1:0]      src_level,
  input  logic [N-1:0]      src_active,
  input  logic [N*32-1:0]   src_dest,
  output logic [N-1:0]      act_set,
  output logic [N-1:0]      act_clr,
  input  logic              tp_we,
  input  logic [3:0]        tp_wdata,
  output logic [3:0]        task_prio,
  input  logic              spur_we,
  input  logic [VEC_W-1:0]  spur_wdata,
  input  logic              ack_rd,
  output logic [VEC_W-1:0]  ack_vec,
  input  logic              eoi_we,
  output logic              irq_out,
  output logic              crit_out
);
  localparam int CRIT_BIT = 30 - CPU_IDX;
  localparam int CMPW     = (PW > TP_W) ? PW : TP_W;

  // Per-source views of the flat table buses
  logic [PW-1:0]    prio_a [N];
  logic [VEC_W-1:0] vec_a  [N];
  logic [N-1:0]     crit_a;
  for (genvar g = 0; g < N; g++) begin : g_src
    assign prio_a[g] = src_prio[g*PW +: PW];
    assign vec_a[g]  = src_vec[g*VEC_W +: VEC_W];
    if (CRIT_EN) begin : g_crit
      assign crit_a[g] = src_dest[g*DEST_W + CRIT_BIT];
    end else begin : g_nocrit
      assign crit_a[g] = 1'b0;
    end
  end
  logic dest_unused;
  assign dest_unused = ^{src_dest, spur_wdata};

  // State
  logic [N-1:0]      pend_q, serv_q;
  logic [N-1:0]      pend_set, pend_clr, serv_set, serv_clr;
  logic [TP_W-1:0]   tp_q;
  logic [SPUR_W-1:0] spur_q;
  logic              irq_q, crit_q, irq_d, crit_d;

  src_bitmap #(.N(N)) u_pend (.clk(clk), .rst_n(rst_n), .set_oh(pend_set), .clr_oh(pend_clr), .q(pend_q));
  src_bitmap #(.N(N)) u_serv (.clk(clk), .rst_n(rst_n), .set_oh(serv_set), .clr_oh(serv_clr), .q(serv_q));

  // Priority selection
  logic          p_any, s_any, s2_any;
  logic [IW-1:0] p_idx, s_idx, s2_idx;
  logic [PW-1:0] p_top, s_top, s2_top;
  logic [N-1:0]  s_oh;

  prio_pick #(.N(N), .PW(PW)) u_pick_pend (.member(pend_q), .prio_flat(src_prio), .any(p_any), .idx(p_idx), .top(p_top));
  prio_pick #(.N(N), .PW(PW)) u_pick_serv (.member(serv_q), .prio_flat(src_prio), .any(s_any), .idx(s_idx), .top(s_top));
  assign s_oh = s_any ? (N'(1) << s_idx) : '0;
  prio_pick #(.N(N), .PW(PW)) u_pick_next (.member(serv_q & ~s_oh), .prio_flat(src_prio), .any(s2_any), .idx(s2_idx), .top(s2_top));

  logic s2_unused;
  assign s2_unused = s2_any ^ (^s2_idx);

  // Command decode: acknowledge, then end-of-interrupt, then offer
  ack_cmd_e cmd;
  always_comb begin
    if (ack_rd)           cmd = CMD_ACK;
    else if (eoi_we)      cmd = CMD_EOI;
    else if (offer_valid) cmd = CMD_OFFER;
    else                  cmd = CMD_IDLE;
  end

  logic [PW-1:0]    off_prio;
  logic [VEC_W-1:0] spur_vec;
  assign off_prio = prio_a[offer_idx];
  assign spur_vec = VEC_W'(spur_q);

  // Next-state logic
  always_comb begin
    pend_set     = '0;
    pend_clr     = '0;
    serv_set     = '0;
    serv_clr     = '0;
    act_set      = '0;
    act_clr      = '0;
    offer_missed = 1'b0;
    ack_vec      = '0;
    irq_d        = irq_q;
    crit_d       = crit_q;
    unique case (cmd)
      CMD_OFFER: begin
        if (CMPW'(off_prio) > CMPW'(tp_q)) begin
          if (pend_q[offer_idx]) begin
            offer_missed = 1'b1;
          end else begin
            act_set[offer_idx]  = 1'b1;
            pend_set[offer_idx] = 1'b1;
            if (off_prio >= p_top && off_prio > s_top) begin
              if (crit_a[offer_idx]) crit_d = 1'b1;
              else                   irq_d  = 1'b1;
            end
          end
        end
      end
      CMD_ACK: begin
        irq_d  = 1'b0;
        crit_d = 1'b0;
        ack_vec = spur_vec;
        if (p_any) begin
          pend_clr[p_idx] = 1'b1;
          if (!src_active[p_idx] || CMPW'(p_top) <= CMPW'(tp_q)) begin
            act_clr[p_idx] = 1'b1;
          end else begin
            serv_set[p_idx] = 1'b1;
            ack_vec = vec_a[p_idx];
            if (!src_level[p_idx]) act_clr[p_idx] = 1'b1;
          end
        end
      end
      CMD_EOI: begin
        serv_clr = s_oh;
        if (p_any && p_top > s2_top) begin
          if (crit_a[p_idx]) crit_d = 1'b1;
          else               irq_d  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp_q   <= '1;
      spur_q <= '1;
      irq_q  <= 1'b0;
      crit_q <= 1'b0;
    end else begin
      if (tp_we)   tp_q   <= tp_wdata;
      if (spur_we) spur_q <= spur_wdata[SPUR_W-1:0];
      irq_q  <= irq_d;
      crit_q <= crit_d;
    end
  end

  assign task_prio = tp_q;
  assign irq_out   = irq_q;
  assign crit_out  = crit_q;
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         offer_valid,
  input logic         ack_rd,
  input logic         eoi_we,
  input logic         tp_we,
  input logic [N-1:0] act_set,
  input logic [N-1:0] act_clr,
  input logic         offer_missed,
  input logic         irq_out,
  input logic         crit_out,
  input logic [3:0]   task_prio
);
  a_r4_set_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act_set));
  a_r7_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act_clr));
  a_r3_missed_no_set: assert property (@(posedge clk) disable iff (!rst_n) offer_missed |-> act_set == '0);
  a_r6_ack_lowers: assert property (@(posedge clk) disable iff (!rst_n) ack_rd |=> (!irq_out && !crit_out));
  a_r12_ack_wins: assert property (@(posedge clk) disable iff (!rst_n) ack_rd |-> (!offer_missed && act_set == '0));
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_out) |-> $past(offer_valid || eoi_we));
  a_r13_tp_hold: assert property (@(posedge clk) disable iff (!rst_n) !tp_we |=> $stable(task_prio));
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .ack_rd(ack_rd), .eoi_we(eoi_we),
  .tp_we(tp_we), .act_set(act_set), .act_clr(act_clr), .offer_missed(offer_missed),
  .irq_out(irq_out), .crit_out(crit_out), .task_prio(task_prio)
);

// File: tb/test_irq_ack_ctrl.sv
`timescale 1ns/1ps
module test_irq_ack_ctrl;
  localparam int N = 4;
  localparam int PW = 4;
  localparam int VW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic offer_valid = 1'b0;
  logic [1:0] offer_idx = '0;
  logic offer_missed;
  logic [PW-1:0] prio [N];
  logic [VW-1:0] vec [N];
  logic [31:0] dest [N];
  logic [N-1:0] level = '0;
  logic [N-1:0] act_m = '0;
  logic [N*PW-1:0] src_prio;
  logic [N*VW-1:0] src_vec;
  logic [N*32-1:0] src_dest;
  logic [N-1:0] act_set, act_clr;
  logic tp_we = 1'b0;
  logic [3:0] tp_wdata = '0;
  logic [3:0] task_prio;
  logic spur_we = 1'b0;
  logic [VW-1:0] spur_wdata = '0;
  logic ack_rd = 1'b0;
  logic [VW-1:0] ack_vec;
  logic eoi_we = 1'b0;
  logic irq_out, crit_out;

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign src_prio[g*PW +: PW] = prio[g];
    assign src_vec[g*VW +: VW]  = vec[g];
    assign src_dest[g*32 +: 32] = dest[g];
  end

  irq_ack_ctrl #(.N(N), .PW(PW), .VEC_W(VW), .SPUR_W(8), .CPU_IDX(1), .CRIT_EN(1'b1)) i_irq_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_idx(offer_idx),
    .offer_missed(offer_missed), .src_prio(src_prio), .src_vec(src_vec), .src_level(level),
    .src_active(act_m), .src_dest(src_dest), .act_set(act_set), .act_clr(act_clr),
    .tp_we(tp_we), .tp_wdata(tp_wdata), .task_prio(task_prio), .spur_we(spur_we),
    .spur_wdata(spur_wdata), .ack_rd(ack_rd), .ack_vec(ack_vec), .eoi_we(eoi_we),
    .irq_out(irq_out), .crit_out(crit_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic offer(input int i, output logic s, output logic m);
    logic [N-1:0] as, ac;
    offer_valid = 1'b1; offer_idx = 2'(i);
    #1; s = act_set[i]; m = offer_missed; as = act_set; ac = act_clr;
    @(negedge clk); offer_valid = 1'b0;
    act_m = (act_m | as) & ~ac;
  endtask

  task automatic ack(output logic [VW-1:0] v, output logic [N-1:0] c);
    logic [N-1:0] as;
    ack_rd = 1'b1;
    #1; v = ack_vec; c = act_clr; as = act_set;
    @(negedge clk); ack_rd = 1'b0;
    act_m = (act_m | as) & ~c;
  endtask

  task automatic eoi();
    eoi_we = 1'b1;
    @(negedge clk); eoi_we = 1'b0;
  endtask

  task automatic set_tp(input int t);
    tp_we = 1'b1; tp_wdata = 4'(t);
    @(negedge clk); tp_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic s, m;
    logic [VW-1:0] v;
    logic [N-1:0] c;
    for (int i = 0; i < N; i++) begin
      prio[i] = '0; vec[i] = 16'h1000 + 16'(i) * 16'h0111; dest[i] = 32'h1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 crit", 32'(crit_out), 0);
    chk("R1 task_prio", 32'(task_prio), 15);
    ack(v, c);
    chk("R1 R6 empty ack spurious", 32'(v), 32'h00FF);

    // R2/R4/R8 sweep over task priority and source priority
    for (int t = 15; t >= 0; t--) begin
      set_tp(t);
      chk("R13 tp write", 32'(task_prio), 32'(t));
      for (int p = 0; p < 16; p++) begin
        prio[0] = 4'(p);
        offer(0, s, m);
        chk("R2 accept iff above task", 32'(s), 32'(p > t));
        chk("R2 no miss", 32'(m), 0);
        chk("R4 line", 32'(irq_out), 32'(p > t));
        if (p > t) begin
          ack(v, c);
          chk("R8 vector", 32'(v), 32'(vec[0]));
          chk("R8 edge clears activity", 32'(act_m[0]), 0);
          chk("R6 line low", 32'(irq_out), 0);
          eoi();
        end
      end
    end
    // t = 0 now

    // R3 missed offer
    prio[1] = 4'd5;
    offer(1, s, m);
    chk("R3 first accepted", 32'(s), 1);
    offer(1, s, m);
    chk("R3 missed pulse", 32'(m), 1);
    chk("R3 no set", 32'(s), 0);
    ack(v, c);
    chk("R3 single entry", 32'(v), 32'(vec[1]));
    ack(v, c);
    chk("R3 nothing left", 32'(v), 32'h00FF);
    eoi();

    // R5 ordering with a tie
    prio[0] = 4'd3; prio[1] = 4'd7; prio[2] = 4'd7; prio[3] = 4'd2;
    for (int i = 3; i >= 0; i--) offer(i, s, m);
    chk("R4 line after offers", 32'(irq_out), 1);
    ack(v, c); chk("R5 first tie lowest index", 32'(v), 32'(vec[1]));
    ack(v, c); chk("R5 second", 32'(v), 32'(vec[2]));
    ack(v, c); chk("R5 third", 32'(v), 32'(vec[0]));
    ack(v, c); chk("R5 fourth", 32'(v), 32'(vec[3]));
    ack(v, c); chk("R5 R6 empty", 32'(v), 32'h00FF);
    for (int i = 0; i < 4; i++) eoi();
    chk("R9 no raise when empty", 32'(irq_out), 0);

    // R7 inactive source and lowered-priority source
    prio[0] = 4'd5; level[0] = 1'b1;
    offer(0, s, m);
    act_m[0] = 1'b0;
    ack(v, c);
    chk("R7 inactive spurious", 32'(v), 32'h00FF);
    chk("R7 inactive clr", 32'(c), 32'b0001);
    level[0] = 1'b0;
    prio[1] = 4'd5;
    offer(1, s, m);
    set_tp(6);
    ack(v, c);
    chk("R7 task raised spurious", 32'(v), 32'h00FF);
    chk("R7 task raised clr", 32'(c), 32'b0010);
    set_tp(0);
    ack(v, c);
    chk("R7 removed from pending", 32'(v), 32'h00FF);

    // R8 level-sensitive keeps activity
    prio[2] = 4'd4; level[2] = 1'b1;
    offer(2, s, m);
    ack(v, c);
    chk("R8 level vector", 32'(v), 32'(vec[2]));
    chk("R8 level no clr", 32'(c), 0);
    chk("R8 level active kept", 32'(act_m[2]), 1);
    eoi();
    act_m[2] = 1'b0; level[2] = 1'b0;

    // R9 nesting
    prio[0] = 4'd3; prio[1] = 4'd6; prio[2] = 4'd2; prio[3] = 4'd6;
    offer(0, s, m); ack(v, c);
    chk("R9 outer", 32'(v), 32'(vec[0]));
    offer(1, s, m);
    chk("R4 nests above in-service", 32'(irq_out), 1);
    ack(v, c);
    chk("R9 inner", 32'(v), 32'(vec[1]));
    offer(3, s, m);
    chk("R4 equal to in-service hidden", 32'(irq_out), 0);
    ack(v, c);
    chk("R9 hidden one still pending", 32'(v), 32'(vec[3]));
    offer(2, s, m);
    chk("R4 below in-service hidden", 32'(irq_out), 0);
    eoi();
    eoi();
    chk("R9 pending 2 not above 3", 32'(irq_out), 0);
    eoi();
    chk("R9 reassert", 32'(irq_out), 1);
    ack(v, c);
    chk("R9 last", 32'(v), 32'(vec[2]));
    eoi();

    // R10 critical line, bit 29 for CPU 1
    prio[3] = 4'd5; dest[3] = 32'h2000_0000;
    offer(3, s, m);
    chk("R10 crit high", 32'(crit_out), 1);
    chk("R10 irq low", 32'(irq_out), 0);
    ack(v, c);
    chk("R10 vector", 32'(v), 32'(vec[3]));
    chk("R6 crit dropped", 32'(crit_out), 0);
    eoi();
    dest[3] = 32'h4000_0000;
    offer(3, s, m);
    chk("R10 other cpu bit gives irq", 32'(irq_out), 1);
    chk("R10 other cpu bit no crit", 32'(crit_out), 0);
    ack(v, c); eoi();

    // R11 spurious width
    spur_we = 1'b1; spur_wdata = 16'hABCD;
    @(negedge clk); spur_we = 1'b0;
    ack(v, c);
    chk("R11 truncated spurious", 32'(v), 32'h00CD);

    // R12 precedence
    prio[0] = 4'd5; prio[1] = 4'd6;
    offer(0, s, m);
    offer_valid = 1'b1; offer_idx = 2'd1; ack_rd = 1'b1;
    #1;
    chk("R12 ack vector", 32'(ack_vec), 32'(vec[0]));
    chk("R12 offer ignored under ack", 32'(act_set), 0);
    @(negedge clk); offer_valid = 1'b0; ack_rd = 1'b0;
    ack(v, c);
    chk("R12 nothing pending", 32'(v), 32'h00CD);
    offer_valid = 1'b1; offer_idx = 2'd1; eoi_we = 1'b1;
    #1;
    chk("R12 offer ignored under eoi", 32'(act_set), 0);
    @(negedge clk); offer_valid = 1'b0; eoi_we = 1'b0;
    ack(v, c);
    chk("R12 still nothing pending", 32'(v), 32'h00CD);
    chk("R12 line low", 32'(irq_out), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule